// File: doc/BRIEF.md
# Register-Controlled MDIO Management Master

This block drives a clause-22 management bus (MDC clock plus a bidirectional MDIO line) from one 32-bit control word. Software loads the word with a target PHY address, a PHY register address, a read/write select, an enable bit, write data and a set busy bit. The block then sends one complete management frame and clears busy when the frame ends. For a read, it places the 16 bits returned by the PHY in the low half of the same word.

Software starts a transaction by writing the word. It then polls the same word until busy reads back as zero, and takes the read data from the low 16 bits. MDC is derived from the system clock by an even divide ratio. MDC rests low between frames, and the MDIO output enable is low while the bus is idle.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control word reads 0, MDC is low, the MDIO output enable is low and MDIO output idles at 1.
- R2: A write to the control word is accepted only while busy (bit 31) is clear. A write made while busy is set is ignored, including a write in the cycle where busy clears. The next write after that cycle is accepted.
- R3: A frame is exactly 32 ones, then start bits 0,1, then opcode 1,0 for a read (bit 27 = 1) or 0,1 for a write (bit 27 = 0). The frame continues with the PHY address from bits 25:21 and then the register address from bits 20:16, each sent MSB first.
- R4: A write frame continues with turnaround bits 1,0, driven by the master, and then bits 15:0 of the word, MSB first. The output enable is high for all 64 bit times.
- R5: In a read frame the output enable is low from the first turnaround bit through the last data bit. The 16 bits sampled there, MSB first, replace bits 15:0 of the word when busy clears. Bits 30:16 keep their values.
- R6: Busy stays set while a frame runs and clears 1 + 64*CLK_DIV cycles after the starting write is accepted. The output enable is never high while busy is clear.
- R7: A word written with busy set and enable (bit 30) clear sends no frame, and busy clears one cycle after the write.
- R8: A PHY address of NUM_PHY (5) or more sends no frame, and busy clears one cycle after the write. Address 4 is a valid target.
- R9: MDC has a period of CLK_DIV system clocks, high for CLK_DIV/2 of them, and is low whenever no frame runs. MDIO output changes only on cycles where MDC falls, and the master samples MDIO at MDC rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Value to load into the control word |
| ctrl_o | output | 32 | Current control word (busy, fields, data) |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
Two updates of the control word can fall in the same cycle: the end of a read frame, which clears busy and loads the returned data, and a software write. The bench raises the write strobe at the exact cycle the frame ends. That cycle is computed from the divide ratio and the 64-bit frame length. The bench then expects the word to show the PHY's read data with the original address fields and busy clear, and expects no further frame to appear. A write issued during the frame's first cycle is also expected to be lost.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS    = 64;
  localparam int IDX_W         = $clog2(FRAME_BITS);
  localparam int PREAMBLE_BITS = 32;
  localparam int TA_POS        = 46;
  localparam int DATA_POS      = 48;
  localparam int DATA_W        = 16;
  localparam int ADDR_W        = 5;

  typedef struct packed {
    logic              busy;
    logic              enable;
    logic [1:0]        spare_hi;
    logic              rd_sel;
    logic              spare_lo;
    logic [ADDR_W-1:0] phy_addr;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] data;
  } ctrl_word_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] regad,
    input logic [DATA_W-1:0] wdata
  );
    logic [1:0] op;
    logic [1:0] ta;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b11 : 2'b10;
    return {{PREAMBLE_BITS{1'b1}}, 2'b01, op, phy, regad, ta,
            rd ? {DATA_W{1'b1}} : wdata};
  endfunction
endpackage

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic period_end_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (!run_i)                         cnt_q <= '0;
    else if (cnt_q == CNT_W'(CLK_DIV - 1))   cnt_q <= '0;
    else                                     cnt_q <= cnt_q + 1'b1;
  end

  assign mdc_o        = run_i && (cnt_q >= CNT_W'(HALF));
  // strobes are valid in the cycle before the edge they announce
  assign rise_o       = run_i && (cnt_q == CNT_W'(HALF - 1));
  assign period_end_o = run_i && (cnt_q == CNT_W'(CLK_DIV - 1));
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              period_end_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic                  active_q, rd_q, bit_q, oe_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] shreg_q;
  logic [FRAME_BITS-1:0] frame_init;
  logic [DATA_W-1:0]     rdata_q;
  logic [IDX_W-1:0]      next_idx;
  logic                  last_bit;

  assign frame_init = build_frame(rd_i, phy_i, reg_i, wdata_i);
  assign next_idx   = idx_q + 1'b1;
  assign last_bit   = (idx_q == IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      shreg_q  <= '0;
      bit_q    <= 1'b1;
      oe_q     <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      rd_q     <= rd_i;
      idx_q    <= '0;
      bit_q    <= frame_init[FRAME_BITS-1];
      shreg_q  <= frame_init << 1;
      oe_q     <= 1'b1;
    end else if (active_q && period_end_i) begin
      if (last_bit) begin
        active_q <= 1'b0;
        oe_q     <= 1'b0;
        bit_q    <= 1'b1;
      end else begin
        idx_q    <= next_idx;
        bit_q    <= shreg_q[FRAME_BITS-1];
        shreg_q  <= shreg_q << 1;
        // release the line from the turnaround on for reads
        oe_q     <= !(rd_q && (next_idx >= IDX_W'(TA_POS)));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      rdata_q <= '0;
    else if (start_i)
      rdata_q <= '0;
    else if (active_q && rise_i && rd_q && (idx_q >= IDX_W'(DATA_POS)))
      rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
  end

  assign active_o  = active_q;
  assign done_o    = active_q && period_end_i && last_bit;
  assign mdio_o    = oe_q ? bit_q : 1'b1;
  assign mdio_oe_o = oe_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/mdio_mgmt_regfile.sv
module mdio_mgmt_regfile
  import mdio_mgmt_pkg::*;
#(
  parameter int NUM_PHY = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              done_i,
  input  logic              eng_active_i,
  input  logic [DATA_W-1:0] rdata_i,
  output ctrl_word_t        ctrl_o,
  output logic              go_o
);
  ctrl_word_t ctrl_q;
  logic       accept, target_ok, drop;

  assign accept    = wr_en_i && !ctrl_q.busy;
  assign target_ok = (32'(ctrl_q.phy_addr) < NUM_PHY);
  assign go_o      = ctrl_q.busy && ctrl_q.enable && target_ok && !eng_active_i;
  assign drop      = ctrl_q.busy && !(ctrl_q.enable && target_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (accept) begin
      ctrl_q <= ctrl_word_t'(wr_data_i);
    end else if (drop) begin
      ctrl_q.busy <= 1'b0;
    end else if (done_i) begin
      ctrl_q.busy <= 1'b0;
      if (ctrl_q.rd_sel) ctrl_q.data <= rdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int NUM_PHY = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] ctrl_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  ctrl_word_t        ctrl;
  logic              go, done, active, rise, period_end;
  logic [DATA_W-1:0] rdata;

  mdio_mgmt_regfile #(.NUM_PHY(NUM_PHY)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .done_i       (done),
    .eng_active_i (active),
    .rdata_i      (rdata),
    .ctrl_o       (ctrl),
    .go_o         (go)
  );

  mdio_mgmt_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (active),
    .mdc_o        (mdc_o),
    .rise_o       (rise),
    .period_end_o (period_end)
  );

  mdio_mgmt_engine u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (go),
    .rd_i         (ctrl.rd_sel),
    .phy_i        (ctrl.phy_addr),
    .reg_i        (ctrl.reg_addr),
    .wdata_i      (ctrl.data),
    .rise_i       (rise),
    .period_end_i (period_end),
    .mdio_i       (mdio_i),
    .active_o     (active),
    .mdio_o       (mdio_o),
    .mdio_oe_o    (mdio_oe_o),
    .done_o       (done),
    .rdata_o      (rdata)
  );

  assign ctrl_o = ctrl;
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
  parameter int NUM_PHY = 5
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] ctrl_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[31] |-> (!mdc_o && !mdio_oe_o));

  assert_change_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_o) |-> $fell(mdc_o));

  assert_busy_write_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[31] && wr_en_i) |=> (ctrl_o[30:16] == $past(ctrl_o[30:16])));

  assert_disabled_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[31] && !ctrl_o[30]) |=> (!ctrl_o[31] && !mdio_oe_o));

  assert_bad_phy_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[31] && (32'(ctrl_o[25:21]) >= NUM_PHY)) |=> !ctrl_o[31]);

  assert_drive_only_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> ctrl_o[31]);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.NUM_PHY(NUM_PHY)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .ctrl_o    (ctrl_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
  localparam int CLK_DIV   = 4;
  localparam int NUM_PHY   = 5;
  localparam int FRAME_CYC = 64 * CLK_DIV;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [31:0] wr_data_i;
  logic [31:0] ctrl_o;
  logic        mdc_o, mdio_i, mdio_o, mdio_oe_o;

  typedef struct {
    bit       rd;
    bit [4:0] phy;
    bit [4:0] ra;
    bit [15:0] data;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int frames_seen = 0;
  int mdc_rises = 0;
  int mdc_hi = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  mdio_mgmt_master #(.CLK_DIV(CLK_DIV), .NUM_PHY(NUM_PHY)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .ctrl_o(ctrl_o), .mdc_o(mdc_o), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o)
  );

  always @(posedge mdc_o) mdc_rises++;
  always @(negedge clk_i) if (mdc_o) mdc_hi++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic logic [15:0] phy_val(input logic [4:0] phy, input logic [4:0] ra);
    return 16'hC3A5 ^ {phy, ra, phy, 1'b1};
  endfunction

  // PHY model and scoreboard monitor
  initial begin
    mdio_i = 1'b1;
    forever begin
      int ones;
      logic [12:0] hdr;
      logic [17:0] tail;
      logic [15:0] rv;
      bit oe_bad;
      exp_t e;
      ones = 0;
      forever begin
        @(posedge mdc_o);
        if (mdio_oe_o && mdio_o) ones++;
        else break;
      end
      chk(ones == 32 && mdio_oe_o && !mdio_o, "R3", "preamble length", ones, 32);
      for (int i = 12; i >= 0; i--) begin
        @(posedge mdc_o);
        hdr[i] = mdio_o;
      end
      if (exp_q.size() == 0) begin
        chk(0, "R3", "unexpected frame", hdr, 0);
        e = '{rd: 0, phy: 0, ra: 0, data: 0};
      end else begin
        e = exp_q.pop_front();
      end
      chk(hdr[12:10] == (e.rd ? 3'b110 : 3'b101), "R3", "start/opcode",
          hdr[12:10], e.rd ? 3'b110 : 3'b101);
      chk(hdr[9:0] == {e.phy, e.ra}, "R3", "address fields", hdr[9:0], {e.phy, e.ra});
      oe_bad = 0;
      if (e.rd) begin
        rv = phy_val(e.phy, e.ra);
        @(posedge mdc_o);
        if (mdio_oe_o) oe_bad = 1;
        @(negedge mdc_o);
        mdio_i = 1'b0;
        @(posedge mdc_o);
        if (mdio_oe_o) oe_bad = 1;
        for (int k = 15; k >= 0; k--) begin
          @(negedge mdc_o);
          mdio_i = rv[k];
          @(posedge mdc_o);
          if (mdio_oe_o) oe_bad = 1;
        end
        chk(!oe_bad, "R5", "line released in turnaround/data", oe_bad, 0);
        frames_seen++;
        @(negedge mdc_o);
        mdio_i = 1'b1;
      end else begin
        for (int i = 17; i >= 0; i--) begin
          @(posedge mdc_o);
          tail[i] = mdio_o;
          if (!mdio_oe_o) oe_bad = 1;
        end
        chk(tail == {2'b10, e.data} && !oe_bad, "R4", "turnaround+write data",
            {oe_bad, tail}, {1'b0, 2'b10, e.data});
        frames_seen++;
      end
    end
  end

  task automatic send(input logic [31:0] word);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = word;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic do_txn(input bit rd, input bit en, input logic [4:0] phy,
                        input logic [4:0] ra, input logic [15:0] wd, input string req);
    logic [31:0] word, exp_word;
    bit valid;
    int n, f0, exp_n;
    word  = {1'b1, en, 2'b00, rd, 1'b0, phy, ra, wd};
    valid = en && (int'(phy) < NUM_PHY);
    if (valid) exp_q.push_back('{rd: rd, phy: phy, ra: ra, data: wd});
    f0 = frames_seen;
    send(word);
    n = 0;
    while (ctrl_o[31] && n < 2 * FRAME_CYC) begin
      n++;
      @(negedge clk_i);
    end
    exp_n = valid ? 1 + FRAME_CYC : 1;
    chk(n == exp_n, valid ? "R6" : req, "busy duration", n, exp_n);
    exp_word = {1'b0, en, 2'b00, rd, 1'b0, phy, ra, (valid && rd) ? phy_val(phy, ra) : wd};
    chk(ctrl_o == exp_word, req, "final control word", ctrl_o, exp_word);
    chk(frames_seen == f0 + int'(valid), req, "frame count", frames_seen, f0 + int'(valid));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R6 actual=hung expected=complete");
    summary();
  end

  initial begin
    int r0, h0;
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    repeat (3) @(negedge clk_i);
    chk(ctrl_o == 0 && !mdc_o && !mdio_oe_o && mdio_o, "R1", "reset state",
        {ctrl_o[28:0], mdc_o, mdio_oe_o, mdio_o}, 32'h1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ctrl_o == 0 && !mdc_o && !mdio_oe_o, "R1", "state after release", ctrl_o, 0);

    // write frame, also measuring MDC (R9)
    r0 = mdc_rises; h0 = mdc_hi;
    do_txn(0, 1, 5'd1, 5'd3, 16'hA55A, "R4");
    chk(mdc_rises - r0 == 64, "R9", "MDC cycles per frame", mdc_rises - r0, 64);
    chk(mdc_hi - h0 == 64 * (CLK_DIV / 2), "R9", "MDC high time", mdc_hi - h0,
        64 * (CLK_DIV / 2));

    do_txn(1, 1, 5'd2, 5'h1F, 16'h0000, "R5");
    do_txn(0, 1, 5'd4, 5'd0, 16'h0001, "R8");
    do_txn(1, 1, 5'd0, 5'h10, 16'hFFFF, "R5");
    do_txn(0, 1, 5'd5, 5'd2, 16'h1234, "R8");
    do_txn(1, 1, 5'd31, 5'd2, 16'h4321, "R8");
    do_txn(0, 0, 5'd1, 5'd3, 16'h5555, "R7");
    do_txn(1, 0, 5'd2, 5'd4, 16'h0000, "R7");

    // R2: writes during the first cycle and the completion cycle are lost
    begin
      int f0;
      logic [31:0] exp_word;
      f0 = frames_seen;
      exp_q.push_back('{rd: 1, phy: 5'd3, ra: 5'd7, data: 16'h0});
      send({1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 5'd3, 5'd7, 16'h0000});
      wr_en_i = 1'b1; wr_data_i = 32'hC022_BEEF;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      repeat (FRAME_CYC - 1) @(negedge clk_i);
      chk(ctrl_o[31] == 1'b1, "R6", "busy before completion edge", ctrl_o[31], 1);
      wr_en_i = 1'b1; wr_data_i = 32'hC022_BEEF;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      exp_word = {1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 5'd3, 5'd7, phy_val(5'd3, 5'd7)};
      chk(ctrl_o == exp_word, "R2", "write in completion cycle ignored", ctrl_o, exp_word);
      repeat (10) @(negedge clk_i);
      chk(frames_seen == f0 + 1 && !ctrl_o[31], "R2", "no frame from lost write",
          frames_seen - f0, 1);
    end

    do_txn(0, 1, 5'd3, 5'd9, 16'h8001, "R2");

    repeat (20) @(negedge clk_i);
    chk(exp_q.size() == 0, "R3", "all expected frames seen", exp_q.size(), 0);
    summary();
  end
endmodule